// File: doc/BRIEF.md
# Bus Transceiver with Shared Parity Pin

This block connects two parallel data ports, A and B, and passes a data word from one to the other in a direction chosen by a single select input. A disable input takes every output off the bus. A single parity pin sits next to the data ports. In transmit mode it carries a parity bit that the block generates from the A word. In receive mode the block samples it and checks it against the B word. In receive mode an error flag shows whether the received word and its parity bit agree with the chosen parity sense. A low flag marks an error. In transmit mode the flag is released. An odd/even select picks the parity sense.

Each pin group is modelled as separate input, output and output-enable signals, so the block needs no on-chip tri-states. The pad ring joins these signals into real bidirectional pins. All outputs and enables are registered. They reflect the inputs sampled at the previous rising clock edge, and a synchronous active-high reset clears them. The data width is a parameter. The default width is 8.

Top module: `bus_parity_xcvr`

## Requirements
- R1: After a reset cycle, every output enable (`a_oe`, `b_oe`, `par_oe`, `flag_oe`) is 0 and every data output is 0.
- R2: One cycle after `dir_i`=1 and `dis_i`=0 are sampled (transmit), `b_oe`=1, `a_oe`=0 and `b_out` equals the sampled `a_in`, bit for bit and noninverted.
- R3: One cycle after `dir_i`=0 and `dis_i`=0 are sampled (receive), `a_oe`=1, `b_oe`=0 and `a_out` equals the sampled `b_in`, noninverted.
- R4: One cycle after `dis_i`=1 is sampled, all four output enables are 0 and all data outputs are 0, whatever the direction.
- R5: In transmit mode with `odd_i`=0 (even sense), `par_oe`=1 and `par_out` is 1 exactly when the number of 1 bits in `a_in` is odd.
- R6: In transmit mode with `odd_i`=1 (odd sense), `par_out` is the inverse of the even-sense value, so `a_in` plus `par_out` hold an odd number of ones.
- R7: In receive mode, `par_oe`=0 and `flag_oe`=1. `flag_out` is 1 (no error) when the count of ones in `b_in` plus `par_in` is even for `odd_i`=0 or odd for `odd_i`=1. Otherwise `flag_out` is 0.
- R8: In transmit mode, `flag_oe`=0 and `flag_out`=0, and `par_in` has no effect on any output.
- R9: `a_oe` and `b_oe` are never 1 in the same cycle, and `par_oe` and `flag_oe` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dir_i | input | 1 | 1: A drives B (transmit); 0: B drives A (receive) |
| dis_i | input | 1 | 1: release all outputs |
| odd_i | input | 1 | Parity sense: 0 even, 1 odd |
| a_in | input | W | Value seen on the A pins |
| b_in | input | W | Value seen on the B pins |
| par_in | input | 1 | Value seen on the parity pin |
| a_out | output | W | Data driven onto A |
| a_oe | output | 1 | Drive enable for A |
| b_out | output | W | Data driven onto B |
| b_oe | output | 1 | Drive enable for B |
| par_out | output | 1 | Generated parity bit |
| par_oe | output | 1 | Drive enable for the parity pin |
| flag_out | output | 1 | Check result, 0 means error |
| flag_oe | output | 1 | Drive enable for the check flag |

## Verification
The hardest case to reach is the receive check. The flag depends jointly on the parity of the B word, the sampled parity pin and the sense select, so one wrong term goes unseen unless every combination of the three is driven. The bench therefore sweeps every B value against both sense settings and both parity-pin levels in receive mode. It makes the same full sweep of A values in transmit mode, where it also toggles the parity pin to show that the pin has no effect. Between sweep points it inserts disabled cycles, so that the release of all outputs is seen after both directions.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef enum logic [1:0] {
    MODE_OFF = 2'd0,
    MODE_TX  = 2'd1,
    MODE_RX  = 2'd2
  } xcvr_mode_e;
endpackage

// File: rtl/xcvr_parity_tree.sv
module xcvr_parity_tree #(
  parameter int W = 8
) (
  input  logic [W-1:0] d,
  output logic         odd_cnt
);
  logic [W:0] acc;
  assign acc[0] = 1'b0;
  for (genvar i = 0; i < W; i++) begin : g_chain
    assign acc[i+1] = acc[i] ^ d[i];
  end
  assign odd_cnt = acc[W];
endmodule

// File: rtl/xcvr_mode_dec.sv
module xcvr_mode_dec
  import xcvr_pkg::*;
(
  input  logic       dir_i,
  input  logic       dis_i,
  output xcvr_mode_e mode
);
  always_comb begin
    if (dis_i)      mode = MODE_OFF;
    else if (dir_i) mode = MODE_TX;
    else            mode = MODE_RX;
  end
endmodule

// File: rtl/bus_parity_xcvr.sv
module bus_parity_xcvr
  import xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         dir_i,
  input  logic         dis_i,
  input  logic         odd_i,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         par_in,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  output logic [W-1:0] b_out,
  output logic         b_oe,
  output logic         par_out,
  output logic         par_oe,
  output logic         flag_out,
  output logic         flag_oe
);
  xcvr_mode_e mode;
  logic a_odd, b_odd;

  xcvr_mode_dec u_dec (.dir_i(dir_i), .dis_i(dis_i), .mode(mode));
  xcvr_parity_tree #(.W(W)) u_pa (.d(a_in), .odd_cnt(a_odd));
  xcvr_parity_tree #(.W(W)) u_pb (.d(b_in), .odd_cnt(b_odd));

  always_ff @(posedge clk) begin
    if (rst) begin
      a_out <= '0; a_oe <= 1'b0;
      b_out <= '0; b_oe <= 1'b0;
      par_out <= 1'b0; par_oe <= 1'b0;
      flag_out <= 1'b0; flag_oe <= 1'b0;
    end else begin
      a_out <= '0; a_oe <= 1'b0;
      b_out <= '0; b_oe <= 1'b0;
      par_out <= 1'b0; par_oe <= 1'b0;
      flag_out <= 1'b0; flag_oe <= 1'b0;
      case (mode)
        MODE_TX: begin
          b_out   <= a_in;
          b_oe    <= 1'b1;
          par_out <= a_odd ^ odd_i;
          par_oe  <= 1'b1;
        end
        MODE_RX: begin
          a_out    <= b_in;
          a_oe     <= 1'b1;
          flag_out <= ~(b_odd ^ par_in ^ odd_i);
          flag_oe  <= 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/xcvr_chk.sv
module xcvr_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         dir_i,
  input logic         dis_i,
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic [W-1:0] a_out,
  input logic         a_oe,
  input logic [W-1:0] b_out,
  input logic         b_oe,
  input logic         par_oe,
  input logic         flag_oe
);
  // R9
  ports_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(a_oe && b_oe));
  // R9
  par_flag_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(par_oe && flag_oe));
  // R4
  disable_release_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(dis_i)) |-> (!a_oe && !b_oe && !par_oe && !flag_oe));
  // R2
  tx_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(dis_i) && $past(dir_i)) |-> (b_oe && b_out == $past(a_in)));
  // R3
  rx_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(dis_i) && !$past(dir_i)) |-> (a_oe && a_out == $past(b_in)));
endmodule

bind bus_parity_xcvr xcvr_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .dir_i(dir_i), .dis_i(dis_i),
  .a_in(a_in), .b_in(b_in), .a_out(a_out), .a_oe(a_oe),
  .b_out(b_out), .b_oe(b_oe), .par_oe(par_oe), .flag_oe(flag_oe)
);

// File: tb/bus_parity_xcvr_tb.sv
module bus_parity_xcvr_tb;
  localparam int W = 8;
  logic clk = 1'b0;
  logic rst, dir_i, dis_i, odd_i, par_in;
  logic [W-1:0] a_in, b_in, a_out, b_out;
  logic a_oe, b_oe, par_out, par_oe, flag_out, flag_oe;
  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  bus_parity_xcvr #(.W(W)) u_dut (
    .clk(clk), .rst(rst), .dir_i(dir_i), .dis_i(dis_i), .odd_i(odd_i),
    .a_in(a_in), .b_in(b_in), .par_in(par_in),
    .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe),
    .par_out(par_out), .par_oe(par_oe), .flag_out(flag_out), .flag_oe(flag_oe)
  );

  // {dir, dis, odd, par_in, a[7:0], b[7:0], exp_par, exp_flag}
  localparam logic [21:0] VEC [8] = '{
    {1'b1,1'b0,1'b0,1'b0,8'h00,8'h00,1'b0,1'b0},
    {1'b1,1'b0,1'b0,1'b1,8'h01,8'h00,1'b1,1'b0},
    {1'b1,1'b0,1'b1,1'b0,8'h00,8'h00,1'b1,1'b0},
    {1'b1,1'b0,1'b1,1'b1,8'hFF,8'h00,1'b1,1'b0},
    {1'b0,1'b0,1'b0,1'b1,8'h00,8'h01,1'b0,1'b1},
    {1'b0,1'b0,1'b0,1'b1,8'h00,8'h03,1'b0,1'b0},
    {1'b0,1'b0,1'b1,1'b1,8'h00,8'h03,1'b0,1'b1},
    {1'b0,1'b0,1'b1,1'b0,8'h00,8'h00,1'b0,1'b0}
  };

  function automatic int ones(input logic [W-1:0] v);
    int c = 0;
    for (int i = 0; i < W; i++) if (v[i]) c++;
    return c;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic d, input logic ds, input logic o, input logic p,
                       input logic [W-1:0] a, input logic [W-1:0] b);
    dir_i = d; dis_i = ds; odd_i = o; par_in = p; a_in = a; b_in = b;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_model(input logic d, input logic ds, input logic o, input logic p,
                             input logic [W-1:0] a, input logic [W-1:0] b);
    if (ds) begin
      check("R4 enables", {a_oe, b_oe, par_oe, flag_oe}, 4'b0000);
      check("R4 data", {a_out, b_out, par_out, flag_out}, '0);
    end else if (d) begin
      check("R2 tx data", {b_oe, a_oe, b_out}, {2'b10, a});
      check("R5 R6 tx parity", {par_oe, par_out},
            {1'b1, ((ones(a) % 2) == 1) != o});
      check("R8 tx flag", {flag_oe, flag_out}, 2'b00);
    end else begin
      check("R3 rx data", {a_oe, b_oe, a_out}, {2'b10, b});
      check("R7 rx flag", {par_oe, flag_oe, flag_out},
            {2'b01, (((ones(b) + int'(p)) % 2) == 1) == o});
    end
    check("R9 exclusive", {a_oe & b_oe, par_oe & flag_oe}, 2'b00);
  endtask

  initial begin
    #(20 * 190000);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    drive(1'b1, 1'b0, 1'b0, 1'b1, 8'hA5, 8'h5A);
    drive(1'b1, 1'b0, 1'b0, 1'b1, 8'hA5, 8'h5A);
    // R1 reset state
    check("R1 enables", {a_oe, b_oe, par_oe, flag_oe}, 4'b0000);
    check("R1 data", {a_out, b_out, par_out, flag_out}, '0);
    rst = 1'b0;

    for (int k = 0; k < 8; k++) begin
      drive(VEC[k][21], VEC[k][20], VEC[k][19], VEC[k][18], VEC[k][17:10], VEC[k][9:2]);
      check(VEC[k][21] ? "R5 R6 table parity" : "R7 table flag",
            VEC[k][21] ? par_out : flag_out, VEC[k][21] ? VEC[k][1] : VEC[k][0]);
      check_model(VEC[k][21], VEC[k][20], VEC[k][19], VEC[k][18], VEC[k][17:10], VEC[k][9:2]);
    end

    // R8: parity pin ignored in transmit
    drive(1'b1, 1'b0, 1'b0, 1'b0, 8'h07, 8'h00);
    check("R8 par_in ignored", {par_out, flag_oe}, 2'b10);
    drive(1'b1, 1'b0, 1'b0, 1'b1, 8'h07, 8'h00);
    check("R8 par_in ignored", {par_out, flag_oe}, 2'b10);

    // Full sweep
    for (int v = 0; v < 256; v++) begin
      for (int m = 0; m < 16; m++) begin
        logic [W-1:0] dv;
        dv = W'(v);
        drive(m[3], m[2], m[1], m[0], dv, ~dv ^ W'(m));
        check_model(m[3], m[2], m[1], m[0], dv, ~dv ^ W'(m));
      end
    end

    // R4 after both directions, then R1 reset mid-run
    drive(1'b0, 1'b1, 1'b1, 1'b1, 8'hFF, 8'hFF);
    check_model(1'b0, 1'b1, 1'b1, 1'b1, 8'hFF, 8'hFF);
    drive(1'b1, 1'b0, 1'b0, 1'b0, 8'h3C, 8'h00);
    rst = 1'b1;
    drive(1'b1, 1'b0, 1'b0, 1'b0, 8'h3C, 8'h00);
    check("R1 reset mid-run", {a_oe, b_oe, par_oe, flag_oe, b_out}, '0);
    rst = 1'b0;

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule